// File: doc/BRIEF.md
# Nibble-Indexed Cartridge Controller

This block sits between a host bus and two small stores: a 32-byte battery-backed RAM and a sixteen-entry, 4-bit clock register file. The host never moves a whole byte at once. It first writes an index to the index port. It then writes a 4-bit value to, or reads a value from, the data port, and the value goes to or comes from the internal register at that index.

Eight writable nibble registers hold several things: the ROM bank number, the two halves of a write byte, and the two parts of the target address. The upper address register also carries a 3-bit command code. Writing the low address nibble starts the command. The command can store a RAM byte, write a clock register, or load minutes or hours in BCD. Reads are combinational and return an 8-bit value whose upper nibble is always set. An external timekeeper updates the clock registers through a separate update port.

Top module: `nib_cart_ctrl`

## Requirements
- R1: After reset (`rst_ni` low), all of the following are zero: the nibble registers, the index, the RAM and the clock registers. So `bank_o` is 0x00, and reading index 0 returns 0xF0.
- R2: A data-port write (`bus_sel_i`=0) stores only `bus_wdata_i[3:0]` into the register at the current index.
- R3: `bank_o` is {register 1, register 0}. It changes only after a data write to index 0 or 1.
- R4: A data write to index 7 starts the command held in register 6 bits [3:1]. The target address is {reg6[0], reg7}. Command 0 stores {reg5, reg4} at that address. Command 1 reads RAM: index 0xC returns 0xF0|byte[3:0] and index 0xD returns 0xF0|byte[7:4].
- R5: Reading index 0xA returns 0xF1. Reading any index other than 0xA, 0xC or 0xD returns 0xF0.
- R6: Command 4 with target address bit 0 clear writes the high nibble of the write byte into the clock register selected by its low nibble. With address bit 0 set, nothing is written.
- R7: With command 4, index 0xC returns 0xF0|clock[reg4], and index 0xD returns 0xF0.
- R8: Command 2 at address 4 loads clock registers 2 (units) and 3 (tens) from the write byte (low nibble = units). At address 5 it loads registers 4 and 5 the same way. Reading at address 6 returns {clock3, clock2} and at address 7 returns {clock5, clock4}, split into nibbles as in R4.
- R9: A command-2 read at any other address returns the 5-bit target address as the byte.
- R10: Commands 3, 5, 6 and 7 change no state, and their reads return 0xF0. Data writes while the index is 0x8 or higher are ignored.
- R11: `tk_we_i` writes `tk_val_i` into clock register `tk_idx_i`. A host clock write to the same entry in the same cycle wins.
- R12: Writes to indices 4, 5 and 6 start no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Host write strobe |
| bus_sel_i | input | 1 | 1 = index port, 0 = data port |
| bus_wdata_i | input | 8 | Host write data (low nibble used) |
| bus_rdata_o | output | 8 | Read data for the current index |
| bank_o | output | 8 | Assembled ROM bank number |
| tk_we_i | input | 1 | Timekeeper update strobe |
| tk_idx_i | input | 4 | Timekeeper target clock register |
| tk_val_i | input | 4 | Timekeeper update value |

## Verification
The hardest situation to reach is a state change that depends on the order of nibble writes. A command fires only on the address-low write, so the operands must already be set up in the other registers, and writes to those registers alone must leave the stores untouched. The stimulus table therefore interleaves operand writes, address-high writes and triggering writes. It rewrites operands between commands and reads back through a different command to prove nothing was stored. One example: minutes are written through command 2 and then read through command 4 to confirm which clock entries they landed in. Simultaneous host and timekeeper writes to the same clock entry are produced in a directed test.

// File: rtl/nib_cart_pkg.sv
package nib_cart_pkg;
  localparam int NIB_W    = 4;
  localparam int NREG     = 8;
  localparam int RAM_DEPTH = 32;
  localparam int CLK_ENT  = 16;
  localparam int RAM_AW   = $clog2(RAM_DEPTH);

  localparam logic [3:0] IX_BANK_LO = 4'h0;
  localparam logic [3:0] IX_BANK_HI = 4'h1;
  localparam logic [3:0] IX_WR_LO   = 4'h4;
  localparam logic [3:0] IX_WR_HI   = 4'h5;
  localparam logic [3:0] IX_ADR_HI  = 4'h6;
  localparam logic [3:0] IX_ADR_LO  = 4'h7;
  localparam logic [3:0] IX_STATUS  = 4'hA;
  localparam logic [3:0] IX_RD_LO   = 4'hC;
  localparam logic [3:0] IX_RD_HI   = 4'hD;

  typedef enum logic [2:0] {
    CMD_RAM_WR = 3'd0,
    CMD_RAM_RD = 3'd1,
    CMD_MISC   = 3'd2,
    CMD_CLK    = 3'd4
  } cmd_e;

  // misc command addresses; clock slots for minutes and hours
  localparam logic [4:0] MISC_MIN_WR = 5'd4;
  localparam logic [4:0] MISC_HR_WR  = 5'd5;
  localparam logic [4:0] MISC_MIN_RD = 5'd6;
  localparam logic [4:0] MISC_HR_RD  = 5'd7;
  localparam logic [3:0] CK_MIN_U = 4'd2;
  localparam logic [3:0] CK_MIN_T = 4'd3;
  localparam logic [3:0] CK_HR_U  = 4'd4;
  localparam logic [3:0] CK_HR_T  = 4'd5;
endpackage

// File: rtl/nib_regfile.sv
module nib_regfile #(
  parameter int NREG = 8,
  parameter int W    = 4,
  localparam int IW  = $clog2(NREG)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [IW-1:0]            idx_i,
  input  logic [W-1:0]             din_i,
  output logic [NREG-1:0][W-1:0]   regs_o
);
  logic [NREG-1:0][W-1:0] regs_q;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          regs_q[g] <= '0;
      else if (we_i && idx_i == IW'(g))     regs_q[g] <= din_i;
    end
  end

  assign regs_o = regs_q;

  assert_mask_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> regs_q[$past(idx_i)] == $past(din_i));
  assert_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(regs_q));
endmodule

// File: rtl/nib_ram.sv
module nib_ram #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DEPTH-1:0][DW-1:0] mem_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          mem_q[g] <= '0;
      else if (we_i && waddr_i == AW'(g))   mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

  assert_ram_store_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i));
  assert_ram_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mem_q));
endmodule

// File: rtl/nib_clk_file.sv
module nib_clk_file #(
  parameter int NENT = 16,
  parameter int W    = 4,
  localparam int IW  = $clog2(NENT)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   a_we_i,
  input  logic [IW-1:0]          a_idx_i,
  input  logic [W-1:0]           a_val_i,
  input  logic                   b_we_i,
  input  logic [IW-1:0]          b_idx_i,
  input  logic [W-1:0]           b_val_i,
  input  logic                   u_we_i,
  input  logic [IW-1:0]          u_idx_i,
  input  logic [W-1:0]           u_val_i,
  output logic [NENT-1:0][W-1:0] regs_o
);
  logic [NENT-1:0][W-1:0] ent_q;

  // host lanes take priority over the timekeeper lane
  for (genvar g = 0; g < NENT; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              ent_q[g] <= '0;
      else if (a_we_i && a_idx_i == IW'(g))     ent_q[g] <= a_val_i;
      else if (b_we_i && b_idx_i == IW'(g))     ent_q[g] <= b_val_i;
      else if (u_we_i && u_idx_i == IW'(g))     ent_q[g] <= u_val_i;
    end
  end

  assign regs_o = ent_q;

  assert_host_lane_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_we_i |=> ent_q[$past(a_idx_i)] == $past(a_val_i));
  assert_host_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_we_i && u_we_i && a_idx_i == u_idx_i) |=> ent_q[$past(u_idx_i)] == $past(a_val_i));
  assert_clk_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!a_we_i && !b_we_i && !u_we_i) |=> $stable(ent_q));
endmodule

// File: rtl/nib_cart_ctrl.sv
module nib_cart_ctrl
  import nib_cart_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bus_we_i,
  input  logic       bus_sel_i,
  input  logic [7:0] bus_wdata_i,
  output logic [7:0] bus_rdata_o,
  output logic [7:0] bank_o,
  input  logic       tk_we_i,
  input  logic [3:0] tk_idx_i,
  input  logic [3:0] tk_val_i
);
  localparam int RIW = $clog2(NREG);
  localparam int CIW = $clog2(CLK_ENT);

  logic [3:0]                    idx_q;
  logic [NREG-1:0][NIB_W-1:0]    nreg;
  logic [CLK_ENT-1:0][NIB_W-1:0] ck;
  logic                          data_we, go;
  logic [2:0]                    cmd;
  logic [RAM_AW-1:0]             wr_addr, rd_addr;
  logic [7:0]                    wr_byte, ram_rd, fetched;
  logic                          ram_we;
  logic                          a_we, b_we;
  logic [CIW-1:0]                a_idx, b_idx;
  logic [NIB_W-1:0]              a_val, b_val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    idx_q <= '0;
    else if (bus_we_i && bus_sel_i) idx_q <= bus_wdata_i[3:0];
  end

  assign data_we = bus_we_i && !bus_sel_i && (idx_q < 4'(NREG));

  nib_regfile #(.NREG(NREG), .W(NIB_W)) u_regs (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (data_we),
    .idx_i (idx_q[RIW-1:0]),
    .din_i (bus_wdata_i[3:0]),
    .regs_o(nreg)
  );

  // command setup; address-low comes from the bus in the trigger cycle
  assign go      = data_we && (idx_q == IX_ADR_LO);
  assign cmd     = nreg[IX_ADR_HI[RIW-1:0]][3:1];
  assign wr_addr = {nreg[IX_ADR_HI[RIW-1:0]][0], bus_wdata_i[3:0]};
  assign rd_addr = {nreg[IX_ADR_HI[RIW-1:0]][0], nreg[IX_ADR_LO[RIW-1:0]]};
  assign wr_byte = {nreg[IX_WR_HI[RIW-1:0]], nreg[IX_WR_LO[RIW-1:0]]};
  assign ram_we  = go && (cmd == CMD_RAM_WR);

  nib_ram #(.DEPTH(RAM_DEPTH), .DW(8)) u_ram (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (ram_we),
    .waddr_i(wr_addr),
    .wdata_i(wr_byte),
    .raddr_i(rd_addr),
    .rdata_o(ram_rd)
  );

  always_comb begin
    a_we  = 1'b0;
    b_we  = 1'b0;
    a_idx = '0;
    b_idx = '0;
    a_val = wr_byte[3:0];
    b_val = wr_byte[7:4];
    if (go && cmd == CMD_MISC) begin
      if (wr_addr == MISC_MIN_WR) begin
        a_we = 1'b1; a_idx = CK_MIN_U;
        b_we = 1'b1; b_idx = CK_MIN_T;
      end else if (wr_addr == MISC_HR_WR) begin
        a_we = 1'b1; a_idx = CK_HR_U;
        b_we = 1'b1; b_idx = CK_HR_T;
      end
    end else if (go && cmd == CMD_CLK && !wr_addr[0]) begin
      a_we  = 1'b1;
      a_idx = wr_byte[3:0];
      a_val = wr_byte[7:4];
    end
  end

  nib_clk_file #(.NENT(CLK_ENT), .W(NIB_W)) u_clk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .a_we_i (a_we),
    .a_idx_i(a_idx),
    .a_val_i(a_val),
    .b_we_i (b_we),
    .b_idx_i(b_idx),
    .b_val_i(b_val),
    .u_we_i (tk_we_i),
    .u_idx_i(tk_idx_i),
    .u_val_i(tk_val_i),
    .regs_o (ck)
  );

  // byte fetched for the read-data indices
  always_comb begin
    fetched = 8'h00;
    unique case (cmd)
      CMD_RAM_RD: fetched = ram_rd;
      CMD_MISC: begin
        if (rd_addr == MISC_MIN_RD)     fetched = {ck[CK_MIN_T], ck[CK_MIN_U]};
        else if (rd_addr == MISC_HR_RD) fetched = {ck[CK_HR_T], ck[CK_HR_U]};
        else                            fetched = {3'b000, rd_addr};
      end
      CMD_CLK: fetched = {4'h0, ck[nreg[IX_WR_LO[RIW-1:0]]]};
      default: fetched = 8'h00;
    endcase
  end

  always_comb begin
    bus_rdata_o = 8'hF0;
    if (idx_q == IX_STATUS) begin
      bus_rdata_o = 8'hF1;
    end else if (idx_q == IX_RD_LO) begin
      bus_rdata_o = 8'hF0 | {4'h0, fetched[3:0]};
    end else if (idx_q == IX_RD_HI) begin
      if (cmd != CMD_CLK) bus_rdata_o = 8'hF0 | {4'h0, fetched[7:4]};
    end
  end

  assign bank_o = {nreg[IX_BANK_HI[RIW-1:0]], nreg[IX_BANK_LO[RIW-1:0]]};

  assert_status_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_q == IX_STATUS) |-> bus_rdata_o == 8'hF1);
  assert_bank_src_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bank_o) |-> $past(bus_we_i && !bus_sel_i && idx_q < 4'd2));
  assert_clk_rdhi_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_q == IX_RD_HI && cmd == 3'd4) |-> bus_rdata_o == 8'hF0);
  assert_no_trigger_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && !bus_sel_i && idx_q != IX_ADR_LO) |-> !ram_we && !a_we && !b_we);
endmodule

// File: tb/nib_cart_ctrl_tb.sv
module nib_cart_ctrl_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bus_we_i = 1'b0;
  logic       bus_sel_i = 1'b0;
  logic [7:0] bus_wdata_i = '0;
  logic [7:0] bus_rdata_o;
  logic [7:0] bank_o;
  logic       tk_we_i = 1'b0;
  logic [3:0] tk_idx_i = '0;
  logic [3:0] tk_val_i = '0;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  nib_cart_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_we_i(bus_we_i), .bus_sel_i(bus_sel_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .bank_o(bank_o),
    .tk_we_i(tk_we_i), .tk_idx_i(tk_idx_i), .tk_val_i(tk_val_i)
  );

  // {op, index, value/expected, requirement}; op 0 write, 1 check read, 2 check bank
  localparam int NV = 66;
  localparam logic [17:0] VEC [NV] = '{
    {2'd1,4'hA,8'hF1,4'd5}, {2'd1,4'h3,8'hF0,4'd5},                         // R5
    {2'd0,4'h0,8'hA7,4'd2}, {2'd0,4'h1,8'h3C,4'd3}, {2'd2,4'h0,8'hC7,4'd3}, // R2 R3
    {2'd0,4'h4,8'h05,4'd4}, {2'd0,4'h5,8'h0A,4'd4}, {2'd0,4'h6,8'h00,4'd4},
    {2'd0,4'h7,8'h03,4'd4}, {2'd0,4'h4,8'h0C,4'd4}, {2'd0,4'h5,8'h06,4'd4},
    {2'd0,4'h6,8'h01,4'd4}, {2'd0,4'h7,8'h03,4'd4}, {2'd0,4'h6,8'h02,4'd4},
    {2'd0,4'h7,8'h03,4'd4}, {2'd1,4'hC,8'hF5,4'd4}, {2'd1,4'hD,8'hFA,4'd4},
    {2'd0,4'h6,8'h03,4'd4}, {2'd1,4'hC,8'hFC,4'd4}, {2'd1,4'hD,8'hF6,4'd4}, // R4
    {2'd0,4'h4,8'h01,4'd12}, {2'd0,4'h5,8'h00,4'd12}, {2'd0,4'h6,8'h00,4'd12},
    {2'd0,4'h6,8'h02,4'd12}, {2'd1,4'hC,8'hF5,4'd12},                       // R12
    {2'd0,4'h6,8'h06,4'd10}, {2'd0,4'h4,8'h0E,4'd10}, {2'd0,4'h5,8'h0E,4'd10},
    {2'd0,4'h7,8'h03,4'd10}, {2'd1,4'hC,8'hF0,4'd10}, {2'd0,4'h6,8'h02,4'd10},
    {2'd1,4'hC,8'hF5,4'd10}, {2'd1,4'hD,8'hFA,4'd10}, {2'd0,4'h8,8'h0F,4'd10},
    {2'd0,4'hC,8'h03,4'd10}, {2'd2,4'h0,8'hC7,4'd10}, {2'd1,4'hA,8'hF1,4'd10}, // R10
    {2'd0,4'h4,8'h09,4'd6}, {2'd0,4'h5,8'h07,4'd6}, {2'd0,4'h6,8'h08,4'd6},
    {2'd0,4'h7,8'h00,4'd6}, {2'd1,4'hC,8'hF7,4'd7}, {2'd1,4'hD,8'hF0,4'd7},   // R6 R7
    {2'd0,4'h5,8'h02,4'd6}, {2'd0,4'h7,8'h01,4'd6}, {2'd1,4'hC,8'hF7,4'd6},
    {2'd0,4'h4,8'h05,4'd8}, {2'd0,4'h5,8'h04,4'd8}, {2'd0,4'h6,8'h04,4'd8},
    {2'd0,4'h7,8'h04,4'd8}, {2'd0,4'h4,8'h03,4'd8}, {2'd0,4'h5,8'h02,4'd8},
    {2'd0,4'h7,8'h05,4'd8}, {2'd0,4'h7,8'h06,4'd8}, {2'd1,4'hC,8'hF5,4'd8},
    {2'd1,4'hD,8'hF4,4'd8}, {2'd0,4'h7,8'h07,4'd8}, {2'd1,4'hC,8'hF3,4'd8},
    {2'd1,4'hD,8'hF2,4'd8}, {2'd0,4'h6,8'h08,4'd8}, {2'd0,4'h4,8'h02,4'd8},
    {2'd1,4'hC,8'hF5,4'd8},                                                 // R8
    {2'd0,4'h6,8'h05,4'd9}, {2'd0,4'h7,8'h06,4'd9}, {2'd1,4'hC,8'hF6,4'd9},
    {2'd1,4'hD,8'hF1,4'd9}                                                  // R9
  };

  task automatic bus_wr(input logic sel, input logic [7:0] v);
    @(negedge clk_i);
    bus_we_i = 1'b1; bus_sel_i = sel; bus_wdata_i = v;
    @(negedge clk_i);
    bus_we_i = 1'b0;
  endtask

  task automatic put(input logic [3:0] ix, input logic [7:0] v);
    bus_wr(1'b1, {4'h0, ix});
    bus_wr(1'b0, v);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic rd_check(input string req, input logic [3:0] ix, input logic [7:0] exp);
    bus_wr(1'b1, {4'h0, ix});
    check(req, bus_rdata_o, exp);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 bank", bank_o, 8'h00);
    check("R1 rdata", bus_rdata_o, 8'hF0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i][3:0], i);
      case (VEC[i][17:16])
        2'd0: put(VEC[i][15:12], VEC[i][11:4]);
        2'd1: rd_check(tag, VEC[i][15:12], VEC[i][11:4]);
        default: check(tag, bank_o, VEC[i][11:4]);
      endcase
    end

    // R11: host and timekeeper hit clock entry 9 in one cycle; host wins
    put(4'h4, 8'h09); put(4'h5, 8'h06); put(4'h6, 8'h08);
    bus_wr(1'b1, 8'h07);
    @(negedge clk_i);
    bus_we_i = 1'b1; bus_sel_i = 1'b0; bus_wdata_i = 8'h00;
    tk_we_i = 1'b1; tk_idx_i = 4'h9; tk_val_i = 4'h1;
    @(negedge clk_i);
    bus_we_i = 1'b0; tk_we_i = 1'b0;
    rd_check("R11 host wins", 4'hC, 8'hF6);
    @(negedge clk_i);
    tk_we_i = 1'b1; tk_idx_i = 4'h9; tk_val_i = 4'h3;
    @(negedge clk_i);
    tk_we_i = 1'b0;
    check("R11 update", bus_rdata_o, 8'hF3);

    // R1: reset mid-run clears everything
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 bank after reset", bank_o, 8'h00);
    check("R1 index after reset", bus_rdata_o, 8'hF0);
    put(4'h6, 8'h02); put(4'h7, 8'h03);
    rd_check("R1 ram lo cleared", 4'hC, 8'hF0);
    rd_check("R1 ram hi cleared", 4'hD, 8'hF0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule